// File: doc/BRIEF.md
# Rotating-Priority Eight-Level Interrupt Controller Core

This core collects eight interrupt request lines and latches them. It chooses the request with the highest priority and raises an interrupt line when that request outranks every level already in service. An acknowledge pulse moves the winning level from pending to in service. When a level is in service, only a level with higher priority can interrupt the processor.

Software controls the core through one write port, which carries an address bit and a data byte. When the address bit is 1, the byte is the request mask. When the address bit is 0, data bits 4:3 route the byte to one of three registers: the priority/end-of-interrupt command register, a status-control register, or the initialization register. The priority command holds a three-bit operation code in data bits 7:5 and a level number in bits 2:0. The operation code selects one of eight actions: turn automatic rotation on or off, clear an in-service level (the top one or a named one), or make a named level the lowest priority. Some codes combine two of these actions. A separate automatic end-of-interrupt mode clears service at acknowledge, and the rotation commands still take effect in that mode.

Top module: `irqc_core`

## Requirements
- R1: After reset, irq is 0 and irq_level is 0. The request, in-service and mask registers are clear, automatic rotation and automatic end-of-interrupt are off, and level 7 is the lowest priority, so level 0 ranks highest.
- R2: A high sample of irq_lines[i] sets request bit i. The bit stays set after the line drops, until level i is acknowledged or an initialization write occurs.
- R3: Priority runs upward from the level just above the current lowest level and wraps past 7 to 0. irq_level shows the highest-priority unmasked pending level, or 0 when no level is pending. irq is 1 only when that level outranks every in-service level.
- R4: An ack while irq is 1 clears the request bit of irq_level. If automatic end-of-interrupt is off, it also sets that level's in-service bit. An ack while irq is 0 has no effect.
- R5: Operation code 001 (nonspecific end of interrupt) clears the highest-priority in-service bit. Data bits 2:0 are ignored for this code and for every code whose bit 6 is 0.
- R6: Code 011 clears the in-service bit named by data bits 2:0. Code 010 does nothing.
- R7: Code 110 makes level data[2:0] the lowest priority. Code 111 does the same and also clears that level's in-service bit.
- R8: Code 100 turns automatic rotation on and code 000 turns it off. Code 101 turns it on and issues a nonspecific end of interrupt. While rotation is on, a level cleared by a nonspecific end of interrupt becomes the lowest priority.
- R9: In automatic end-of-interrupt mode, an acknowledged level never enters service. If rotation is on, the acknowledged level becomes the lowest priority.
- R10: With the address bit 0 and data bits 4:3 = 01, a write is a status-control write and changes no request, service or priority state. With data bit 4 = 1, a write is an initialization write: it clears the request, in-service and mask registers, turns rotation off, makes level 7 the lowest, and sets automatic end-of-interrupt mode to data bit 0.
- R11: With the address bit 1, the data byte becomes the mask. A masked level keeps its request latched but does not compete for irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 8 | Request inputs, one per level |
| wr_en | input | 1 | Write strobe for the command port |
| wr_addr | input | 1 | 1 writes the mask; 0 routes by data bits 4:3 |
| wr_data | input | 8 | Command or mask byte |
| ack | input | 1 | Acknowledge pulse for the current winner |
| irq | output | 1 | Interrupt request to the processor |
| irq_level | output | 3 | Winning pending level |

## Verification
Directed sequences test nesting. A higher-priority request must break through an in-service level, and a lower-priority one must stay blocked. Each end-of-interrupt code is given a level field that points at an idle level, which separates the nonspecific codes from the specific ones. Named rotations and automatic rotations are each followed by a pair of requests that only the new priority order resolves correctly. A status-control byte is written whose top bits would clear service if it were decoded as a priority command. A long random stream of requests, acknowledges, masks and commands is then checked on every clock against a behavioural model of the rank order.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int unsigned N_LVL = 8;
    localparam int unsigned LVL_W = $clog2(N_LVL);

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [N_LVL-1:0] vec_t;

    typedef enum logic [2:0] {
        OP_ROT_OFF    = 3'b000,
        OP_NS_EOI     = 3'b001,
        OP_NOP        = 3'b010,
        OP_SP_EOI     = 3'b011,
        OP_ROT_ON     = 3'b100,
        OP_ROT_NS     = 3'b101,
        OP_SP_ROT     = 3'b110,
        OP_SP_ROT_EOI = 3'b111
    } prio_op_e;

    typedef struct packed {
        logic rot_set;
        logic rot_clr;
        logic ns_eoi;
        logic sp_eoi;
        logic sp_rot;
        lvl_t lvl;
        logic status_wr;
        logic init;
        logic aeoi_val;
        logic mask_wr;
        vec_t mask_val;
    } cmd_t;

    // distance from the slot just above the lowest level; 0 is top priority
    function automatic lvl_t rank_of(lvl_t l, lvl_t low);
        return lvl_t'(l - low - lvl_t'(1));
    endfunction
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
    import irqc_pkg::*;
(
    input  logic       wr_en,
    input  logic       wr_addr,
    input  logic [7:0] wr_data,
    output cmd_t       cmd
);
    prio_op_e op;
    assign op = prio_op_e'(wr_data[7:5]);

    always_comb begin
        cmd = '0;
        if (wr_en) begin
            if (wr_addr) begin
                cmd.mask_wr  = 1'b1;
                cmd.mask_val = vec_t'(wr_data);
            end else if (wr_data[4]) begin
                cmd.init     = 1'b1;
                cmd.aeoi_val = wr_data[0];
            end else if (wr_data[3]) begin
                cmd.status_wr = 1'b1;
            end else begin
                // level field only meaningful when the specific flag is set
                if (wr_data[6]) cmd.lvl = lvl_t'(wr_data[2:0]);
                unique case (op)
                    OP_ROT_OFF:    cmd.rot_clr = 1'b1;
                    OP_NS_EOI:     cmd.ns_eoi  = 1'b1;
                    OP_NOP:        ;
                    OP_SP_EOI:     cmd.sp_eoi  = 1'b1;
                    OP_ROT_ON:     cmd.rot_set = 1'b1;
                    OP_ROT_NS: begin
                        cmd.rot_set = 1'b1;
                        cmd.ns_eoi  = 1'b1;
                    end
                    OP_SP_ROT:     cmd.sp_rot  = 1'b1;
                    OP_SP_ROT_EOI: begin
                        cmd.sp_rot = 1'b1;
                        cmd.sp_eoi = 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/irqc_resolve.sv
module irqc_resolve
    import irqc_pkg::*;
(
    input  vec_t bits,
    input  lvl_t low,
    output logic hit,
    output lvl_t lvl
);
    // walk from the lowest-priority slot toward the top so the last match wins
    always_comb begin
        hit = 1'b0;
        lvl = '0;
        for (int k = N_LVL - 1; k >= 0; k--) begin
            lvl_t idx;
            idx = lvl_t'(low + lvl_t'(k) + lvl_t'(1));
            if (bits[idx]) begin
                hit = 1'b1;
                lvl = idx;
            end
        end
    end
endmodule

// File: rtl/irqc_core.sv
module irqc_core
    import irqc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] irq_lines,
    input  logic       wr_en,
    input  logic       wr_addr,
    input  logic [7:0] wr_data,
    input  logic       ack,
    output logic       irq,
    output logic [2:0] irq_level
);
    vec_t irr_q, isr_q, mask_q;
    lvl_t low_q;
    logic rot_q, aeoi_q;

    vec_t irr_d, isr_d, mask_d;
    lvl_t low_d;
    logic rot_d, aeoi_d;

    cmd_t cmd;
    vec_t pend;
    logic p_hit, s_hit, take;
    lvl_t p_lvl, s_lvl;

    irqc_decode u_dec (
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .cmd    (cmd)
    );

    assign pend = irr_q & ~mask_q;

    irqc_resolve u_pend (.bits(pend),  .low(low_q), .hit(p_hit), .lvl(p_lvl));
    irqc_resolve u_svc  (.bits(isr_q), .low(low_q), .hit(s_hit), .lvl(s_lvl));

    assign irq       = p_hit && (!s_hit || (rank_of(p_lvl, low_q) < rank_of(s_lvl, low_q)));
    assign irq_level = p_lvl;
    assign take      = ack && irq;

    always_comb begin
        irr_d  = irr_q | vec_t'(irq_lines);
        isr_d  = isr_q;
        mask_d = mask_q;
        low_d  = low_q;
        rot_d  = rot_q;
        aeoi_d = aeoi_q;

        if (take) begin
            irr_d = (irr_q & ~(vec_t'(1) << p_lvl)) | vec_t'(irq_lines);
            if (!aeoi_q)    isr_d[p_lvl] = 1'b1;
            else if (rot_q) low_d = p_lvl;
        end

        if (cmd.rot_clr) rot_d = 1'b0;
        if (cmd.rot_set) rot_d = 1'b1;
        if (cmd.ns_eoi && s_hit) begin
            isr_d[s_lvl] = 1'b0;
            if (rot_d) low_d = s_lvl;
        end
        if (cmd.sp_eoi) isr_d[cmd.lvl] = 1'b0;
        if (cmd.sp_rot) low_d = cmd.lvl;
        if (cmd.mask_wr) mask_d = cmd.mask_val;

        if (cmd.init) begin
            irr_d  = '0;
            isr_d  = '0;
            mask_d = '0;
            low_d  = lvl_t'(N_LVL - 1);
            rot_d  = 1'b0;
            aeoi_d = cmd.aeoi_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irr_q  <= '0;
            isr_q  <= '0;
            mask_q <= '0;
            low_q  <= lvl_t'(N_LVL - 1);
            rot_q  <= 1'b0;
            aeoi_q <= 1'b0;
        end else begin
            irr_q  <= irr_d;
            isr_q  <= isr_d;
            mask_q <= mask_d;
            low_q  <= low_d;
            rot_q  <= rot_d;
            aeoi_q <= aeoi_d;
        end
    end

    // R3
    irq_pend_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> pend[irq_level]);

    // R4
    ack_svc_chk: assert property (@(posedge clk) disable iff (rst)
        (take && !aeoi_q && !wr_en) |=> isr_q[$past(irq_level)]);

    // R6
    sp_eoi_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.sp_eoi && !take) |=> !isr_q[$past(cmd.lvl)]);

    // R7
    sp_rot_chk: assert property (@(posedge clk) disable iff (rst)
        cmd.sp_rot |=> (low_q == $past(cmd.lvl)));

    // R9
    aeoi_chk: assert property (@(posedge clk) disable iff (rst)
        (take && aeoi_q && !wr_en) |=> !isr_q[$past(irq_level)]);

    // R10
    status_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.status_wr && !take) |=> ($stable(isr_q) && $stable(low_q) && $stable(rot_q)));

    // R10
    init_chk: assert property (@(posedge clk) disable iff (rst)
        cmd.init |=> (isr_q == '0 && irr_q == '0 && !irq));
endmodule

// File: tb/tb_irqc_core.sv
module tb_irqc_core;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] irq_lines = '0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = '0;
    logic       ack = 1'b0;
    logic       irq;
    logic [2:0] irq_level;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irqc_core dut (
        .clk(clk), .rst(rst), .irq_lines(irq_lines), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .ack(ack),
        .irq(irq), .irq_level(irq_level)
    );

    // behavioural reference model
    logic [7:0] m_irr, m_isr, m_mask;
    int m_low;
    bit m_rot, m_aeoi;

    function automatic int mrank(int l);
        return (l - m_low + 15) % 8;
    endfunction

    function automatic int mbest(logic [7:0] v);
        int best = -1;
        for (int i = 0; i < 8; i++)
            if (v[i] && (best < 0 || mrank(i) < mrank(best))) best = i;
        return best;
    endfunction

    function automatic bit m_irq();
        int p = mbest(m_irr & ~m_mask);
        int s = mbest(m_isr);
        return (p >= 0) && (s < 0 || mrank(p) < mrank(s));
    endfunction

    function automatic int m_vec();
        int p = mbest(m_irr & ~m_mask);
        return (p < 0) ? 0 : p;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_irr = 0; m_isr = 0; m_mask = 0; m_low = 7; m_rot = 0; m_aeoi = 0;
        end else begin
            logic [7:0] nirr;
            bit fire;
            int p, s, code, lv;
            fire = m_irq();
            p = m_vec();
            s = mbest(m_isr);
            nirr = m_irr | irq_lines;
            if (ack && fire) begin
                nirr = (m_irr & ~(8'b1 << p)) | irq_lines;
                if (!m_aeoi) m_isr[p] = 1'b1;
                else if (m_rot) m_low = p;
            end
            if (wr_en) begin
                if (wr_addr) m_mask = wr_data;
                else if (wr_data[4]) begin
                    nirr = 0; m_isr = 0; m_mask = 0; m_low = 7; m_rot = 0;
                    m_aeoi = wr_data[0];
                end else if (!wr_data[3]) begin
                    code = int'(wr_data[7:5]);
                    lv = int'(wr_data[2:0]);
                    if (code == 0) m_rot = 0;
                    if (code == 4 || code == 5) m_rot = 1;
                    if ((code == 1 || code == 5) && s >= 0) begin
                        m_isr[s] = 1'b0;
                        if (m_rot) m_low = s;
                    end
                    if (code == 3 || code == 7) m_isr[lv] = 1'b0;
                    if (code == 6 || code == 7) m_low = lv;
                end
            end
            m_irr = nirr;
        end
    end

    string cur_req = "R3";

    task automatic compare();
        total++;
        if (irq !== m_irq() || int'(irq_level) != m_vec()) begin
            bad++;
            $display("FAIL %s cycle compare: irq=%0b level=%0d expected irq=%0b level=%0d",
                     cur_req, irq, irq_level, m_irq(), m_vec());
        end
    endtask

    task automatic drive(input logic [7:0] rq, input logic a, input logic we,
                         input logic wa, input logic [7:0] wd);
        @(negedge clk);
        if (!rst) compare();
        irq_lines = rq; ack = a; wr_en = we; wr_addr = wa; wr_data = wd;
    endtask

    task automatic idle();
        drive(8'h00, 1'b0, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic req(input logic [7:0] rq);
        drive(rq, 1'b0, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic do_ack();
        drive(8'h00, 1'b1, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic cmdw(input logic [7:0] wd);
        drive(8'h00, 1'b0, 1'b1, 1'b0, wd);
    endtask

    task automatic maskw(input logic [7:0] wd);
        drive(8'h00, 1'b0, 1'b1, 1'b1, wd);
    endtask

    task automatic expect_out(input string tag, input logic eirq, input int evec);
        total++;
        if (irq !== eirq || int'(irq_level) != evec) begin
            bad++;
            $display("FAIL %s: irq=%0b level=%0d expected irq=%0b level=%0d",
                     tag, irq, irq_level, eirq, evec);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        idle();
        expect_out("R1", 1'b0, 0);

        // R2 latched requests survive the line dropping
        req(8'b0010_1000); idle();
        expect_out("R2", 1'b1, 3);
        idle(); idle();
        expect_out("R2", 1'b1, 3);

        // R3 nesting: 5 blocked by 3 in service, 1 breaks through
        do_ack(); idle();
        expect_out("R3", 1'b0, 5);
        do_ack(); idle();   // R4 ack while irq low is ignored
        req(8'b0000_0010); idle();
        expect_out("R3", 1'b1, 1);
        do_ack(); idle();
        expect_out("R3", 1'b0, 5);

        // R5 nonspecific EOI with level field 5 clears level 1 only
        cmdw(8'b001_00_101); idle();
        expect_out("R5", 1'b0, 5);
        // R6 specific EOI on level 3 releases 5
        cmdw(8'b011_00_011); idle();
        expect_out("R6", 1'b1, 5);
        expect_out("R4", 1'b1, 5);
        cmdw(8'b010_00_011); idle();
        expect_out("R6", 1'b1, 5);
        do_ack(); cmdw(8'b011_00_101); idle();
        expect_out("R6", 1'b0, 0);

        // R7 specific rotation: level 4 lowest
        cmdw(8'b110_00_100);
        req(8'b0100_0100); idle();
        expect_out("R7", 1'b1, 6);
        do_ack(); idle();
        expect_out("R7", 1'b0, 2);
        cmdw(8'b111_00_110); idle();
        expect_out("R7", 1'b1, 2);
        do_ack(); cmdw(8'b011_00_010); idle();

        // R8 automatic rotation
        cmdw(8'b100_00_000);
        req(8'b1000_0001); idle();
        expect_out("R8", 1'b1, 7);
        do_ack(); cmdw(8'b001_00_000); idle();
        expect_out("R8", 1'b1, 0);
        do_ack(); cmdw(8'b101_00_000);
        req(8'b1000_0010); idle();
        expect_out("R8", 1'b1, 1);
        cmdw(8'b000_00_000);
        do_ack(); idle();
        expect_out("R8", 1'b0, 7);
        cmdw(8'b001_00_000); idle();
        expect_out("R8", 1'b1, 7);
        do_ack(); cmdw(8'b011_00_111); idle();

        // R11 mask
        req(8'b0001_1000); idle();
        expect_out("R11", 1'b1, 3);
        maskw(8'b0000_1000); idle();
        expect_out("R11", 1'b1, 4);
        maskw(8'b0000_0000); idle();
        expect_out("R11", 1'b1, 3);

        // R10 status write is not a priority command
        do_ack(); idle();
        expect_out("R10", 1'b0, 4);
        cmdw(8'b001_01_000); idle();
        expect_out("R10", 1'b0, 4);
        // R10 initialization with automatic EOI on
        cmdw(8'b000_10_001); idle();
        expect_out("R10", 1'b0, 0);

        // R9 automatic EOI with rotation
        cmdw(8'b100_00_000);
        req(8'b0000_1000); idle();
        expect_out("R9", 1'b1, 3);
        do_ack();
        req(8'b0001_0100); idle();
        expect_out("R9", 1'b1, 4);
        do_ack(); idle();
        expect_out("R9", 1'b1, 2);
        cmdw(8'b000_10_000); idle();

        // random stream checked against the model on every cycle
        cur_req = "R3 random";
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] rq;
            logic [7:0] wd;
            int pick;
            rq = 8'($urandom) & 8'($urandom) & 8'($urandom);
            wd = 8'($urandom);
            pick = int'($urandom % 12);
            if (pick == 0) begin
                if (wd[4] && ($urandom % 4 != 0)) wd[4] = 1'b0;
                drive(rq, 1'b0, 1'b1, 1'b0, wd);
            end else if (pick == 1) begin
                drive(rq, 1'b0, 1'b1, 1'b1, wd & 8'($urandom));
            end else begin
                drive(rq, 1'($urandom % 3 == 0), 1'b0, 1'b0, 8'h00);
            end
        end
        idle(); idle();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule